// File: doc/BRIEF.md
# Table-Driven Incremental PID Duty Compensator

This block closes the digital control loop of a switching regulator without any multiplier. Once per switching period a strobe presents a small signed error code. The block saturates that code to the nine levels from -4 to +4. It then reads three signed coefficient products from on-chip tables. The first product is taken for the present error, the second for the error one period back, and the third for the error two periods back. These three terms are added to the stored duty state. The sum is clamped into a 9-bit unsigned range and kept as the new state. The upper eight bits of the state form the duty command sent to the pulse-width modulator.

After reset the tables are empty. A word-serial load port with a valid/ready handshake fills them, one 25-bit word per error level. Regulation starts only after the ninth word has been accepted. While the tables are loading, the duty output stays at zero and any strobe is ignored.

The controller has two named states. In `ST_LOAD` the port is ready and the load address counts from 0 to 8. The transition `load_last` is taken when word 8 is accepted, and it moves the block to `ST_RUN`. In `ST_RUN` the port is closed, `load_done_o` is high, and each strobe performs one `update`. Only reset leaves `ST_RUN`.

Top module: `pid_lut_comp`

## Requirements
- R1: After reset, `ld_ready_o` is 1, `load_done_o` is 0 and `duty_o` is 0.
- R2: Each cycle with `ld_valid_i` high while ready stores one word. The k-th accepted word (k = 0..8) belongs to error code k-4. Bits [24:17] of the word hold the signed present-error term, bits [16:8] the signed one-back term, and bits [7:0] the signed two-back term. When word 8 is accepted, `load_done_o` rises on the next cycle and `ld_ready_o` falls.
- R3: A strobe that arrives before `load_done_o` is high has no effect. This holds even in the cycle that accepts the last load word. Duty stays 0 and the error history stays zero.
- R4: On each strobe in the run state, the new state is the old state plus T0(e[n]) + T1(e[n-1]) + T2(e[n-2]). The sum is formed without wrap-around. The history then shifts by one.
- R5: `duty_o` equals state bits [8:1]. It changes in the cycle after the strobe edge and holds steady until the next strobe.
- R6: An error input outside -4..+4 (4-bit signed, -8..+7) is used as -4 or +4, whichever is nearer.
- R7: A sum below 0 stores 0, and a sum above 511 stores 511. The stored state never goes beyond these limits, so there is no windup.
- R8: When loading completes, the state equals the parameter `INIT_ST` (default 256, so duty is 128). Both history slots equal error 0.
- R9: Load words offered after `load_done_o` are not accepted, and the tables keep their contents.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ld_valid_i | input | 1 | Load word valid |
| ld_data_i | input | 25 | Load word: three packed signed table entries |
| ld_ready_o | output | 1 | Load port ready (tables loading) |
| load_done_o | output | 1 | All nine words loaded, regulation running |
| strobe_i | input | 1 | One-cycle sample strobe, once per switching period |
| err_i | input | 4 | Signed error code |
| duty_o | output | 8 | Unsigned duty command |

## Verification
The two functions that can fall in the same cycle are table loading and a sample update. The bench asserts a strobe with a nonzero error in exactly the cycle that accepts the ninth load word. It then requires that the duty read in the next cycle equals half of the initial state. It also requires that the first real update matches a model whose history is still all zeros. Load words offered later, while strobes are running, must leave every subsequent duty value equal to the model that is built from the original tables.

// File: rtl/pid_lut_pkg.sv
package pid_lut_pkg;
    typedef enum logic {
        ST_LOAD = 1'b0,
        ST_RUN  = 1'b1
    } comp_state_t;
endpackage

// File: rtl/err_level_sat.sv
module err_level_sat #(
    parameter int ERR_W   = 4,
    parameter int ERR_MAX = 4,
    parameter int IDX_W   = 4
) (
    input  logic signed [ERR_W-1:0] err_i,
    output logic [IDX_W-1:0]        idx_o
);
    int val;

    always_comb begin
        val = int'(err_i);
        if (val > ERR_MAX) begin
            val = ERR_MAX;
        end else if (val < -ERR_MAX) begin
            val = -ERR_MAX;
        end
        idx_o = IDX_W'(val + ERR_MAX);
    end
endmodule

// File: rtl/coef_store.sv
module coef_store #(
    parameter int N_ENT  = 9,
    parameter int IDX_W  = 4,
    parameter int T0_W   = 8,
    parameter int T1_W   = 9,
    parameter int T2_W   = 8,
    localparam int WORD_W = T0_W + T1_W + T2_W
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   we_i,
    input  logic [IDX_W-1:0]       waddr_i,
    input  logic [WORD_W-1:0]      wdata_i,
    input  logic [IDX_W-1:0]       idx0_i,
    input  logic [IDX_W-1:0]       idx1_i,
    input  logic [IDX_W-1:0]       idx2_i,
    output logic signed [T0_W-1:0] t0_o,
    output logic signed [T1_W-1:0] t1_o,
    output logic signed [T2_W-1:0] t2_o
);
    logic [T0_W-1:0] tab0 [N_ENT];
    logic [T1_W-1:0] tab1 [N_ENT];
    logic [T2_W-1:0] tab2 [N_ENT];

    for (genvar k = 0; k < N_ENT; k++) begin : g_ent
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                tab0[k] <= '0;
                tab1[k] <= '0;
                tab2[k] <= '0;
            end else if (we_i && (waddr_i == IDX_W'(k))) begin
                tab0[k] <= wdata_i[WORD_W-1 -: T0_W];
                tab1[k] <= wdata_i[T1_W+T2_W-1 -: T1_W];
                tab2[k] <= wdata_i[T2_W-1:0];
            end
        end
    end

    assign t0_o = $signed(tab0[idx0_i]);
    assign t1_o = $signed(tab1[idx1_i]);
    assign t2_o = $signed(tab2[idx2_i]);
endmodule

// File: rtl/acc_clamp.sv
module acc_clamp #(
    parameter int ST_W = 9,
    parameter int T0_W = 8,
    parameter int T1_W = 9,
    parameter int T2_W = 8
) (
    input  logic [ST_W-1:0]        st_i,
    input  logic signed [T0_W-1:0] t0_i,
    input  logic signed [T1_W-1:0] t1_i,
    input  logic signed [T2_W-1:0] t2_i,
    output logic [ST_W-1:0]        st_o
);
    localparam int ST_MAX = (1 << ST_W) - 1;
    int sum;

    always_comb begin
        sum = int'(st_i) + int'(t0_i) + int'(t1_i) + int'(t2_i);
        if (sum < 0) begin
            st_o = '0;
        end else if (sum > ST_MAX) begin
            st_o = ST_W'(ST_MAX);
        end else begin
            st_o = ST_W'(sum);
        end
    end
endmodule

// File: rtl/pid_lut_comp.sv
module pid_lut_comp
    import pid_lut_pkg::*;
#(
    parameter int ERR_W   = 4,
    parameter int ERR_MAX = 4,
    parameter int T0_W    = 8,
    parameter int T1_W    = 9,
    parameter int T2_W    = 8,
    parameter int DUTY_W  = 8,
    parameter int INIT_ST = 256,
    localparam int N_ENT  = 2 * ERR_MAX + 1,
    localparam int IDX_W  = $clog2(N_ENT),
    localparam int WORD_W = T0_W + T1_W + T2_W,
    localparam int ST_W   = DUTY_W + 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ld_valid_i,
    input  logic [WORD_W-1:0] ld_data_i,
    output logic              ld_ready_o,
    output logic              load_done_o,
    input  logic              strobe_i,
    input  logic [ERR_W-1:0]  err_i,
    output logic [DUTY_W-1:0] duty_o
);
    localparam logic [IDX_W-1:0] IDX_ZERO = IDX_W'(ERR_MAX);
    localparam logic [IDX_W-1:0] IDX_LAST = IDX_W'(N_ENT - 1);

    comp_state_t      fsm_q, fsm_d;
    logic [IDX_W-1:0] addr_q;
    logic [IDX_W-1:0] hist1_q, hist2_q, idx_now;
    logic [ST_W-1:0]  st_q, st_next;
    logic             accept, load_last, update;
    logic signed [T0_W-1:0] t0;
    logic signed [T1_W-1:0] t1;
    logic signed [T2_W-1:0] t2;

    assign accept    = ld_valid_i && ld_ready_o;
    assign load_last = accept && (addr_q == IDX_LAST);
    assign update    = strobe_i && load_done_o;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            fsm_q <= ST_LOAD;
        end else begin
            fsm_q <= fsm_d;
        end
    end

    // next state
    always_comb begin
        fsm_d = fsm_q;
        unique case (fsm_q)
            ST_LOAD: if (load_last) fsm_d = ST_RUN;
            ST_RUN:  fsm_d = ST_RUN;
        endcase
    end

    // outputs of the state machine
    always_comb begin
        ld_ready_o  = 1'b0;
        load_done_o = 1'b0;
        unique case (fsm_q)
            ST_LOAD: ld_ready_o  = 1'b1;
            ST_RUN:  load_done_o = 1'b1;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            addr_q <= '0;
        end else if (accept && !load_last) begin
            addr_q <= addr_q + IDX_W'(1);
        end
    end

    err_level_sat #(
        .ERR_W  (ERR_W),
        .ERR_MAX(ERR_MAX),
        .IDX_W  (IDX_W)
    ) u_sat (
        .err_i(err_i),
        .idx_o(idx_now)
    );

    coef_store #(
        .N_ENT(N_ENT),
        .IDX_W(IDX_W),
        .T0_W (T0_W),
        .T1_W (T1_W),
        .T2_W (T2_W)
    ) u_store (
        .clk    (clk),
        .rst_n  (rst_n),
        .we_i   (accept),
        .waddr_i(addr_q),
        .wdata_i(ld_data_i),
        .idx0_i (idx_now),
        .idx1_i (hist1_q),
        .idx2_i (hist2_q),
        .t0_o   (t0),
        .t1_o   (t1),
        .t2_o   (t2)
    );

    acc_clamp #(
        .ST_W(ST_W),
        .T0_W(T0_W),
        .T1_W(T1_W),
        .T2_W(T2_W)
    ) u_acc (
        .st_i(st_q),
        .t0_i(t0),
        .t1_i(t1),
        .t2_i(t2),
        .st_o(st_next)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            hist1_q <= IDX_ZERO;
            hist2_q <= IDX_ZERO;
            st_q    <= ST_W'(INIT_ST);
        end else if (update) begin
            hist1_q <= idx_now;
            hist2_q <= hist1_q;
            st_q    <= st_next;
        end
    end

    assign duty_o = load_done_o ? st_q[ST_W-1:1] : '0;

    AST_ADDR_IN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        addr_q <= IDX_LAST); // R2
    AST_DONE_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        load_done_o |=> load_done_o); // R2
    AST_HIST_FROZEN_LOADING: assert property (@(posedge clk) disable iff (!rst_n)
        ld_ready_o |=> ($stable(hist1_q) && $stable(hist2_q))); // R3
    AST_DUTY_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        (load_done_o && $past(load_done_o) && !$past(strobe_i)) |-> $stable(duty_o)); // R5
    AST_PORT_CLOSED_RUN: assert property (@(posedge clk) disable iff (!rst_n)
        load_done_o |-> !ld_ready_o); // R9
endmodule

// File: tb/pid_lut_comp_bench.sv
module pid_lut_comp_bench;
    localparam int CLK_PERIOD = 10;
    localparam int INIT_ST = 256;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        ld_valid = 1'b0;
    logic [24:0] ld_data = '0;
    logic        ld_ready, load_done;
    logic        strobe = 1'b0;
    logic [3:0]  err = '0;
    logic [7:0]  duty;

    int n_chk = 0;
    int n_fail = 0;
    bit finished = 1'b0;
    int tA [9];
    int tB [9];
    int tC [9];
    int m_st, m_e1, m_e2;

    always #(CLK_PERIOD/2) clk = ~clk;

    pid_lut_comp u_pid_lut_comp (
        .clk        (clk),
        .rst_n      (rst_n),
        .ld_valid_i (ld_valid),
        .ld_data_i  (ld_data),
        .ld_ready_o (ld_ready),
        .load_done_o(load_done),
        .strobe_i   (strobe),
        .err_i      (err),
        .duty_o     (duty)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    function automatic int sat_err(input int e);
        return (e > 4) ? 4 : ((e < -4) ? -4 : e);
    endfunction

    function automatic int model_step(input int e);
        int s;
        s = m_st + tA[e + 4] + tB[m_e1 + 4] + tC[m_e2 + 4];
        if (s < 0) s = 0;
        if (s > 511) s = 511;
        return s;
    endfunction

    task automatic do_update(input int e_raw, input string req);
        int e;
        e = sat_err(e_raw);
        @(negedge clk);
        err = 4'(e_raw);
        strobe = 1'b1;
        @(negedge clk);
        strobe = 1'b0;
        m_st = model_step(e);
        m_e2 = m_e1;
        m_e1 = e;
        chk(duty == 8'(m_st >> 1), req, int'(duty), m_st >> 1);
    endtask

    initial begin
        int seed_v;
        int d0;
        seed_v = $urandom(32'd1357);
        for (int k = 0; k < 9; k++) begin
            tA[k] = int'($urandom_range(255)) - 128;
            tB[k] = int'($urandom_range(511)) - 256;
            tC[k] = int'($urandom_range(255)) - 128;
        end
        tA[8] = 127;  tB[8] = 255;  tC[8] = 127;
        tA[0] = -128; tB[0] = -256; tC[0] = -128;
        m_st = INIT_ST; m_e1 = 0; m_e2 = 0;

        repeat (3) @(negedge clk);
        // R1: reset values
        chk(ld_ready == 1'b1, "R1 ready", int'(ld_ready), 1);
        chk(load_done == 1'b0, "R1 done", int'(load_done), 0);
        chk(duty == 8'd0, "R1 duty", int'(duty), 0);
        rst_n = 1'b1;

        // R3: strobe while loading, ignored
        @(negedge clk);
        err = 4'd3; strobe = 1'b1;
        @(negedge clk);
        strobe = 1'b0;
        chk(duty == 8'd0, "R3 duty zero while loading", int'(duty), 0);

        for (int k = 0; k < 9; k++) begin
            ld_valid = 1'b1;
            ld_data = {tA[k][7:0], tB[k][8:0], tC[k][7:0]};
            if (k == 8) begin
                strobe = 1'b1; err = 4'(-3);
            end
            @(negedge clk);
            if (k < 8) chk(load_done == 1'b0, "R2 not done early", int'(load_done), 0);
        end
        ld_valid = 1'b0; strobe = 1'b0;
        chk(load_done == 1'b1, "R2 done after ninth word", int'(load_done), 1);
        chk(ld_ready == 1'b0, "R2 ready drops", int'(ld_ready), 0);
        // R8 and R3: the coincident strobe was ignored, initial state shown
        chk(duty == 8'(INIT_ST >> 1), "R8 initial duty", int'(duty), INIT_ST >> 1);

        // R9: words offered after done must not change tables
        @(negedge clk);
        ld_valid = 1'b1; ld_data = '1;
        @(negedge clk);
        chk(ld_ready == 1'b0, "R9 port closed", int'(ld_ready), 0);
        ld_valid = 1'b0;

        // R4/R8: first update uses zero history
        do_update(1, "R4 first update zero history");
        do_update(-2, "R9 tables intact");
        // R5: hold between strobes
        d0 = int'(duty);
        repeat (5) @(negedge clk);
        chk(int'(duty) == d0, "R5 hold", int'(duty), d0);

        // R7: drive to upper clamp
        for (int i = 0; i < 4; i++) do_update(4, "R7 toward high");
        chk(duty == 8'd255, "R7 high clamp", int'(duty), 255);
        // R7: drive to lower clamp, no windup
        for (int i = 0; i < 4; i++) do_update(-4, "R7 toward low");
        chk(duty == 8'd0, "R7 low clamp", int'(duty), 0);
        // R6: out of range codes
        do_update(7, "R6 +7 as +4");
        do_update(-8, "R6 -8 as -4");
        do_update(5, "R6 +5 as +4");

        // random stream with gaps, words offered meanwhile (R9)
        for (int i = 0; i < 300; i++) begin
            int e_r;
            e_r = int'($urandom_range(15)) - 8;
            ld_valid = $urandom_range(1) == 1;
            ld_data = 25'($urandom);
            do_update(e_r, "R4 random update");
            repeat ($urandom_range(3)) begin
                d0 = int'(duty);
                @(negedge clk);
                chk(int'(duty) == d0, "R5 random hold", int'(duty), d0);
            end
        end
        ld_valid = 1'b0;

        finished = 1'b1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog R4 actual=%0d expected=%0d", 0, 1);
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end
endmodule